// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational 20-bit binary adder. It adds two operands and a single carry-in, and it produces a 20-bit sum and a carry-out. The operand bits are split into five slices whose widths grow toward the most significant end: 2, 3, 4, 5 and 6 bits.

The lowest slice is a plain ripple chain fed by the external carry-in. Every higher slice holds two ripple chains that run side by side. One assumes that no carry enters the slice and the other assumes that one does. When the real carry arrives from the slice below, a two-way selector passes on the matching sum bits and slice carry-out. Each slice is one bit wider than the one below it. The slice therefore has slightly more ripple time in which to finish its two guesses before its select carry arrives, and the worst-case path grows roughly with the square root of the width rather than linearly.

The adder holds no state and has no clock. Its outputs follow its inputs within the same evaluation.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every pair of 20-bit operands and every carry-in, the 21-bit value {carry_out, sum_out} equals op_a + op_b + carry_in.
- R2: The slices cover bits [1:0], [4:2], [8:5], [13:9] and [19:14]. Changing operand bits at or above any slice boundary (2, 5, 9, 14) never changes the sum bits below that boundary.
- R3: In every slice above the lowest, the result computed for an incoming carry of 1 equals the result computed for an incoming carry of 0 plus one, taken over the slice width plus its carry-out bit.
- R4: In every slice above the lowest, the carry-out computed for an incoming carry of 1 is never below the carry-out computed for an incoming carry of 0.
- R5: With op_a all ones, op_b zero and carry_in 1, the carry runs through every slice: sum_out is zero and carry_out is 1.
- R6: When op_a XOR op_b is all ones, carry_out equals carry_in and every sum_out bit equals the inverse of carry_in.
- R7: With both operands all ones and carry_in 1, sum_out is all ones and carry_out is 1.
- R8: The outputs are combinational. A new input value shows at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 20 | First operand |
| op_b | input | 20 | Second operand |
| carry_in | input | 1 | Carry into the least significant bit |
| sum_out | output | 20 | Sum bits |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
A fault inside one slice has two possible causes: a broken chain guess or a selector that picks the wrong guess. Either one shows at the ports as soon as the inputs settle, but only for operand patterns that route the carry through the faulty slice. For this reason the stimulus includes carries generated exactly at each slice boundary, propagate-only patterns that need the carry to pass through every slice, and the two all-ones corner cases. The checker compares the two guesses inside each slice against each other, so a wrong guess is flagged even when the selector happens to discard it.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int FIRST_W_DEF = 2;
    localparam int NUM_BLK_DEF = 5;

    // Bit position where slice idx starts, for slices first_w, first_w+1, ...
    function automatic int blk_base(input int first_w, input int idx);
        return idx * first_w + (idx * (idx - 1)) / 2;
    endfunction

    function automatic int blk_width(input int first_w, input int idx);
        return first_w + idx;
    endfunction

    function automatic int total_width(input int first_w, input int nblk);
        return blk_base(first_w, nblk);
    endfunction

    localparam int MAX_BLK_W = FIRST_W_DEF + NUM_BLK_DEF - 1;

    // One precomputed slice result, zero-extended to the widest slice
    typedef struct packed {
        logic                 cout;
        logic [MAX_BLK_W-1:0] sum;
    } blk_res_t;

endpackage

// File: rtl/csel_full_adder.sv
module csel_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (y & ci) | (x & ci);
    end
endmodule

// File: rtl/csel_ripple_chain.sv
module csel_ripple_chain #(
    parameter int W = 2
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] link;

    assign link[0] = ci;

    for (genvar k = 0; k < W; k++) begin : g_cell
        csel_full_adder u_fa (
            .x  (x[k]),
            .y  (y[k]),
            .ci (link[k]),
            .s  (s[k]),
            .co (link[k+1])
        );
    end

    assign co = link[W];
endmodule

// File: rtl/csel_select_block.sv
module csel_select_block #(
    parameter int W = 3
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co,
    output logic [W-1:0] s_if0,
    output logic         co_if0,
    output logic [W-1:0] s_if1,
    output logic         co_if1
);
    csel_ripple_chain #(.W(W)) u_chain0 (
        .x  (x),
        .y  (y),
        .ci (1'b0),
        .s  (s_if0),
        .co (co_if0)
    );

    csel_ripple_chain #(.W(W)) u_chain1 (
        .x  (x),
        .y  (y),
        .ci (1'b1),
        .s  (s_if1),
        .co (co_if1)
    );

    always_comb begin
        if (ci) begin
            s  = s_if1;
            co = co_if1;
        end else begin
            s  = s_if0;
            co = co_if0;
        end
    end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
    import csel_pkg::*;
#(
    parameter int  FIRST_W = FIRST_W_DEF,
    parameter int  NUM_BLK = NUM_BLK_DEF,
    localparam int WIDTH   = total_width(FIRST_W, NUM_BLK)
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int RES_W = FIRST_W + NUM_BLK - 1;

    typedef struct packed {
        logic             cout;
        logic [RES_W-1:0] sum;
    } res_t;

    // carry entering each slice; index NUM_BLK is the adder carry-out
    logic [NUM_BLK:0] blk_carry;
    res_t             guess0 [NUM_BLK];
    res_t             guess1 [NUM_BLK];

    assign blk_carry[0] = carry_in;

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        localparam int W    = blk_width(FIRST_W, i);
        localparam int BASE = blk_base(FIRST_W, i);

        logic [W-1:0] sx, sy, ss;

        assign sx = op_a[BASE +: W];
        assign sy = op_b[BASE +: W];

        if (i == 0) begin : g_first
            csel_ripple_chain #(.W(W)) u_chain (
                .x  (sx),
                .y  (sy),
                .ci (blk_carry[i]),
                .s  (ss),
                .co (blk_carry[i+1])
            );
            assign guess0[i] = {blk_carry[i+1], RES_W'(ss)};
            assign guess1[i] = {blk_carry[i+1], RES_W'(ss)};
        end else begin : g_sel
            logic [W-1:0] s0, s1;
            logic         c0, c1;
            csel_select_block #(.W(W)) u_sel (
                .x      (sx),
                .y      (sy),
                .ci     (blk_carry[i]),
                .s      (ss),
                .co     (blk_carry[i+1]),
                .s_if0  (s0),
                .co_if0 (c0),
                .s_if1  (s1),
                .co_if1 (c1)
            );
            assign guess0[i] = {c0, RES_W'(s0)};
            assign guess1[i] = {c1, RES_W'(s1)};
        end

        assign sum_out[BASE +: W] = ss;
    end

    assign carry_out = blk_carry[NUM_BLK];
endmodule

// File: rtl/sqrt_csel_adder_chk.sv
module sqrt_csel_adder_chk #(
    parameter int FIRST_W = 2,
    parameter int NUM_BLK = 5,
    parameter int WIDTH   = 20,
    parameter int RES_W   = 6
) (
    input logic [WIDTH-1:0]   op_a,
    input logic [WIDTH-1:0]   op_b,
    input logic               carry_in,
    input logic [WIDTH-1:0]   sum_out,
    input logic               carry_out,
    input logic [RES_W:0]     g0 [NUM_BLK],
    input logic [RES_W:0]     g1 [NUM_BLK]
);
    always_comb begin
        // R1
        sum_match_chk: assert ({carry_out, sum_out} ==
                               ({1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(carry_in)))
            else $error("sum_match_chk: adder result wrong");

        // R6
        if ((op_a ^ op_b) == {WIDTH{1'b1}}) begin
            propagate_chk: assert (carry_out == carry_in &&
                                   sum_out == {WIDTH{~carry_in}})
                else $error("propagate_chk: propagate pattern wrong");
        end

        for (int i = 1; i < NUM_BLK; i++) begin
            int unsigned w, v0, v1, mask;
            w    = FIRST_W + i;
            mask = (32'd1 << (w + 1)) - 1;
            v0   = ({31'd0, g0[i][RES_W]} << w) | 32'(g0[i][RES_W-1:0]);
            v1   = ({31'd0, g1[i][RES_W]} << w) | 32'(g1[i][RES_W-1:0]);
            // R3
            pair_step_chk: assert (v1 == ((v0 + 1) & mask))
                else $error("pair_step_chk: slice %0d guesses disagree", i);
            // R4
            carry_order_chk: assert (!(g0[i][RES_W] && !g1[i][RES_W]))
                else $error("carry_order_chk: slice %0d carry order wrong", i);
        end
    end
endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk #(
    .FIRST_W (FIRST_W),
    .NUM_BLK (NUM_BLK),
    .WIDTH   (WIDTH),
    .RES_W   (RES_W)
) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .g0        (guess0),
    .g1        (guess1)
);

// File: tb/sqrt_csel_adder_tb.sv
module sqrt_csel_adder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 20;
    localparam int WATCHDOG   = 50000;
    localparam int NVEC       = 14;

    // each entry {op_a, op_b, carry_in}
    localparam logic [2*W:0] VEC [NVEC] = '{
        {20'h00000, 20'h00000, 1'b0},
        {20'h00003, 20'h00001, 1'b0},
        {20'h0001F, 20'h00001, 1'b0},
        {20'h001FF, 20'h00001, 1'b0},
        {20'h03FFF, 20'h00001, 1'b0},
        {20'hAAAAA, 20'h55555, 1'b0},
        {20'hAAAAA, 20'h55555, 1'b1},
        {20'h80000, 20'h80000, 1'b0},
        {20'h12345, 20'h6789A, 1'b1},
        {20'hFFFFF, 20'h00000, 1'b1},
        {20'hFFFFF, 20'hFFFFF, 1'b1},
        {20'hFFFFF, 20'hFFFFF, 1'b0},
        {20'h0F0F0, 20'hF0F0F, 1'b1},
        {20'h00002, 20'h00002, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;

    int  checks   = 0;
    int  failures = 0;
    int  cycles   = 0;
    bit  finished = 0;

    sqrt_csel_adder u_dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cycles <= 0;
        else cycles <= cycles + 1;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired: got %0d cycles, expected <= %0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c;
        #1;
    endtask

    task automatic check_total(input string req);
        logic [W:0] exp;
        exp = {1'b0, op_a} + {1'b0, op_b} + (W+1)'(carry_in);
        checks++;
        if ({carry_out, sum_out} !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h cin=%b: got %h expected %h",
                     req, op_a, op_b, carry_in, {carry_out, sum_out}, exp);
        end
    endtask

    task automatic check_val(input string req, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2357;

        repeat (3) @(posedge clk);
        // R8: quiet inputs give a zero result with no clock involvement
        #1;
        check_val("R8 idle", {carry_out, sum_out}, '0);
        @(negedge clk);
        rst = 1'b0;

        // R1 table walk (covers R5, R6, R7 rows)
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]);
            check_total("R1 table");
        end

        // R5 carry through every slice
        apply('1, '0, 1'b1);
        check_val("R5 full propagate", {carry_out, sum_out}, {1'b1, {W{1'b0}}});

        // R7 both all ones with carry
        apply('1, '1, 1'b1);
        check_val("R7 all ones", {carry_out, sum_out}, {1'b1, {W{1'b1}}});

        // R6 propagate-only operands, both carry values
        apply(20'h5A5A5, 20'hA5A5A, 1'b0);
        check_val("R6 cin0", {carry_out, sum_out}, {1'b0, {W{1'b1}}});
        apply(20'h5A5A5, 20'hA5A5A, 1'b1);
        check_val("R6 cin1", {carry_out, sum_out}, {1'b1, {W{1'b0}}});

        // R3 R4: carry generated at each slice top, and not
        apply(20'h00002, 20'h00002, 1'b0);
        check_val("R3 slice0 gen", {carry_out, sum_out}, 21'h00004);
        apply(20'h03E00, 20'h00200, 1'b0);
        check_val("R4 slice3 gen", {carry_out, sum_out}, 21'h04000);

        // R8: outputs follow input change with no edge
        @(negedge clk);
        op_a = 20'h00010; op_b = 20'h00020; carry_in = 1'b0;
        #1;
        check_val("R8 comb", {carry_out, sum_out}, 21'h00030);
        op_b = 20'h00021;
        #1;
        check_val("R8 comb2", {carry_out, sum_out}, 21'h00031);

        // R2: upper bits never disturb lower slices
        for (int n = 0; n < 200; n++) begin
            logic [W-1:0] a0, b0, lowsum;
            int bound;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a0 = lfsr[19:0];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b0 = lfsr[19:0];
            case (n % 4)
                0: bound = 2;
                1: bound = 5;
                2: bound = 9;
                default: bound = 14;
            endcase
            apply(a0, b0, lfsr[5]);
            lowsum = sum_out & ((20'd1 << bound) - 1);
            apply(a0 ^ (~20'd0 << bound), b0 ^ (lfsr[27:8] << bound), lfsr[5]);
            check_val("R2 slice isolation", {1'b0, sum_out & ((20'd1 << bound) - 1)},
                      {1'b0, lowsum});
        end

        // R1 pseudo-random sweep
        for (int n = 0; n < 2000; n++) begin
            logic [W-1:0] a0;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a0 = lfsr[19:0];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(a0, lfsr[19:0], lfsr[25]);
            check_total("R1 sweep");
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule